// File: doc/BRIEF.md
# LPC reset and shutdown controller

This block sits beside the register bank of an LPC host-bus peripheral and decides which of five reset or shutdown sources is in force. The sources are a chip-level reset (reset input or watchdog overflow), the bus reset pin, a software reset control bit, a hardware power-down pin, and a software shutdown control bit. Only the highest-ranked active source is acted on. The block reports that source as a mode code. It pulses clear strobes back into the register bank so that each level wipes only its own subset of control bits.

The same mode drives a per-pad float request. The address/data lines, frame, clock, serial interrupt and clock-run pads are released whenever any source is active. The four sideband pads are released only when their function-enable bit is set. The bus reset input and the power-down input are never released, because those two pins are how the host brings the peripheral back.

Every output is registered, so each output shows the sources that were sampled at the previous rising edge.

Top module: `lpc_rsc_top`

## Requirements
- R1: `mode_o` shows, one clock after sampling, the highest-ranked active source. The codes are 0 idle, 1 software shutdown, 2 hardware shutdown, 3 software reset, 4 bus reset, 5 system reset.
- R2: System reset is `rst` or `wdt_ovf_i`. It outranks every other source and raises all four clear strobes: `clr_all_o`, `clr_swrst_o`, `clr_sden_o` and `clr_swsdn_o`.
- R3: Bus reset (`bus_rst_i`=1) ranks second. It raises `clr_swrst_o`, `clr_sden_o` and `clr_swsdn_o`, and keeps `clr_all_o` low.
- R4: Software reset (`sw_rst_bit_i`=1) ranks third. It raises `clr_sden_o` and `clr_swsdn_o` only, so the software-reset bit itself is left intact.
- R5: Hardware shutdown is active when `pd_i`=1 and `sdn_en_bit_i`=1. It raises only `clr_swsdn_o`.
- R6: Software shutdown is active when `sw_sdn_bit_i`=1 and `sdn_en_bit_i`=1. It raises no clear strobe. When `sdn_en_bit_i`=0, both shutdown inputs are ignored.
- R7: When several sources are active together, only the winner's mode and clear set appear on the outputs.
- R8: Pads 0 to 7 are the four data lines, then frame, clock, serial interrupt and clock-run. Their `pad_hiz_o` bits are 1 whenever `mode_o` is not 0.
- R9: Pads 8 to 11 are SCI, SMI, PME and gate-A20, gated by `sb_en_i` bits 0 to 3. Each pad floats in a non-idle mode only if its enable bit was 1 at sampling.
- R10: Pad 12 (bus reset input) and pad 13 (power-down input) never float.
- R11: On the first clock after every source has deasserted, `mode_o` returns to 0, all clear strobes go to 0 and all of `pad_hiz_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wdt_ovf_i | input | 1 | Watchdog overflow, acts as system reset |
| bus_rst_i | input | 1 | Bus reset pin, asserted high |
| sw_rst_bit_i | input | 1 | Software reset control bit |
| pd_i | input | 1 | Hardware power-down pin, asserted high |
| sdn_en_bit_i | input | 1 | Shutdown function enable bit |
| sw_sdn_bit_i | input | 1 | Software shutdown control bit |
| sb_en_i | input | 4 | Sideband function enables: SCI, SMI, PME, gate-A20 |
| mode_o | output | 3 | Winning source code |
| clr_all_o | output | 1 | Clear every control bit, including channel enables |
| clr_swrst_o | output | 1 | Clear the software reset bit |
| clr_sden_o | output | 1 | Clear the shutdown enable bit |
| clr_swsdn_o | output | 1 | Clear the software shutdown bit |
| pad_hiz_o | output | 14 | Per-pad float request |

## Verification
The bench raises every source together and then removes them one by one from the top. A priority inverted or flattened would leak a lower level's mode, or add strobes to the winner's set. It checks that software reset leaves the software-reset strobe low; a design that cleared it would cancel its own reset request. It sets alternate sideband enable patterns so that a swapped or ungated sideband bit shows up as a wrong float mask. It holds the shutdown inputs with the enable bit low, which catches a design that ignores the gate. It also checks the single-cycle return to idle, where a sticky float would keep the bus pads released.

// File: rtl/lpc_rsc_pkg.sv
package lpc_rsc_pkg;

  localparam int NUM_LEVELS = 5;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_SW_SDN  = 3'd1,
    MODE_HW_SDN  = 3'd2,
    MODE_SW_RST  = 3'd3,
    MODE_BUS_RST = 3'd4,
    MODE_SYS_RST = 3'd5
  } mode_e;

  typedef struct packed {
    logic all;
    logic swrst;
    logic sden;
    logic swsdn;
  } clr_t;

endpackage

// File: rtl/lpc_rsc_prio.sv
module lpc_rsc_prio
  import lpc_rsc_pkg::*;
#(
  parameter int LEVELS = NUM_LEVELS
) (
  input  logic [LEVELS:1] req_i,
  output mode_e           win_o
);

  // Ascending scan: the last (highest) set level wins.
  always_comb begin
    win_o = MODE_IDLE;
    for (int i = 1; i <= LEVELS; i++) begin
      if (req_i[i]) win_o = mode_e'(i[2:0]);
    end
  end

endmodule

// File: rtl/lpc_rsc_clr.sv
module lpc_rsc_clr
  import lpc_rsc_pkg::*;
(
  input  mode_e mode_i,
  output clr_t  clr_o
);

  // Each level wipes its own bits plus everything the levels below wipe.
  always_comb begin
    clr_o.all   = (mode_i == MODE_SYS_RST);
    clr_o.swrst = (mode_i >= MODE_BUS_RST);
    clr_o.sden  = (mode_i >= MODE_SW_RST);
    clr_o.swsdn = (mode_i >= MODE_HW_SDN);
  end

endmodule

// File: rtl/lpc_rsc_pad.sv
module lpc_rsc_pad #(
  parameter int DATA_W   = 4,
  parameter int NUM_SB   = 4,
  parameter int CORE_N   = DATA_W + 4,
  parameter int NUM_PADS = CORE_N + NUM_SB + 2
) (
  input  logic                float_i,
  input  logic [NUM_SB-1:0]   sb_en_i,
  output logic [NUM_PADS-1:0] hiz_o
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    if (p < CORE_N) begin : g_core
      assign hiz_o[p] = float_i;
    end else if (p < CORE_N + NUM_SB) begin : g_side
      assign hiz_o[p] = float_i & sb_en_i[p - CORE_N];
    end else begin : g_exempt
      assign hiz_o[p] = 1'b0;
    end
  end

endmodule

// File: rtl/lpc_rsc_top.sv
module lpc_rsc_top
  import lpc_rsc_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int NUM_SB   = 4,
  parameter int CORE_N   = DATA_W + 4,
  parameter int NUM_PADS = CORE_N + NUM_SB + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wdt_ovf_i,
  input  logic                bus_rst_i,
  input  logic                sw_rst_bit_i,
  input  logic                pd_i,
  input  logic                sdn_en_bit_i,
  input  logic                sw_sdn_bit_i,
  input  logic [NUM_SB-1:0]   sb_en_i,
  output logic [2:0]          mode_o,
  output logic                clr_all_o,
  output logic                clr_swrst_o,
  output logic                clr_sden_o,
  output logic                clr_swsdn_o,
  output logic [NUM_PADS-1:0] pad_hiz_o
);

  logic [NUM_LEVELS:1] req;
  mode_e               win;
  clr_t                clr_d;
  logic [NUM_PADS-1:0] hiz_d;

  assign req[MODE_SYS_RST] = rst | wdt_ovf_i;
  assign req[MODE_BUS_RST] = bus_rst_i;
  assign req[MODE_SW_RST]  = sw_rst_bit_i;
  assign req[MODE_HW_SDN]  = pd_i & sdn_en_bit_i;
  assign req[MODE_SW_SDN]  = sw_sdn_bit_i & sdn_en_bit_i;

  lpc_rsc_prio #(.LEVELS(NUM_LEVELS)) u_prio (
    .req_i (req),
    .win_o (win)
  );

  lpc_rsc_clr u_clr (
    .mode_i (win),
    .clr_o  (clr_d)
  );

  lpc_rsc_pad #(
    .DATA_W   (DATA_W),
    .NUM_SB   (NUM_SB),
    .CORE_N   (CORE_N),
    .NUM_PADS (NUM_PADS)
  ) u_pad (
    .float_i (win != MODE_IDLE),
    .sb_en_i (sb_en_i),
    .hiz_o   (hiz_d)
  );

  // rst is itself the top-ranked source, so one path loads every register.
  always_ff @(posedge clk) begin
    mode_o      <= win;
    clr_all_o   <= clr_d.all;
    clr_swrst_o <= clr_d.swrst;
    clr_sden_o  <= clr_d.sden;
    clr_swsdn_o <= clr_d.swsdn;
    pad_hiz_o   <= hiz_d;
  end

endmodule

// File: rtl/lpc_rsc_chk.sv
module lpc_rsc_chk #(
  parameter int DATA_W   = 4,
  parameter int NUM_SB   = 4,
  parameter int CORE_N   = DATA_W + 4,
  parameter int NUM_PADS = CORE_N + NUM_SB + 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wdt_ovf_i,
  input logic                bus_rst_i,
  input logic                sw_rst_bit_i,
  input logic                pd_i,
  input logic                sdn_en_bit_i,
  input logic                sw_sdn_bit_i,
  input logic [NUM_SB-1:0]   sb_en_i,
  input logic [2:0]          mode_o,
  input logic                clr_all_o,
  input logic                clr_swrst_o,
  input logic                clr_sden_o,
  input logic                clr_swsdn_o,
  input logic [NUM_PADS-1:0] pad_hiz_o
);

  logic any_src;
  assign any_src = wdt_ovf_i | bus_rst_i | sw_rst_bit_i |
                   (sdn_en_bit_i & (pd_i | sw_sdn_bit_i));

  a_r1_legal_mode: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd5);

  a_r2_wdt_wins: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf_i |=> (mode_o == 3'd5) && clr_all_o && clr_swrst_o);

  a_r3_bus_rst: assert property (@(posedge clk) disable iff (rst)
    (bus_rst_i && !wdt_ovf_i) |=> (mode_o == 3'd4) && !clr_all_o && clr_swrst_o);

  a_r4_keep_swrst: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3) |-> !clr_swrst_o && clr_sden_o && clr_swsdn_o);

  a_r5_hw_sdn_clears: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |-> clr_swsdn_o && !clr_sden_o);

  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    (!sdn_en_bit_i && !wdt_ovf_i && !bus_rst_i && !sw_rst_bit_i) |=> (mode_o == 3'd0));

  a_r7_nesting: assert property (@(posedge clk) disable iff (rst)
    (!clr_all_o || clr_swrst_o) && (!clr_swrst_o || clr_sden_o) && (!clr_sden_o || clr_swsdn_o));

  a_r8_core_float: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 3'd0) |-> (&pad_hiz_o[CORE_N-1:0]));

  a_r9_side_gate: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 3'd0) |-> (pad_hiz_o[CORE_N +: NUM_SB] == $past(sb_en_i)));

  a_r10_exempt: assert property (@(posedge clk) disable iff (rst)
    pad_hiz_o[NUM_PADS-1 -: 2] == 2'b00);

  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    !any_src |=> (mode_o == 3'd0) && (pad_hiz_o == '0) && !clr_swsdn_o);

endmodule

bind lpc_rsc_top lpc_rsc_chk #(
  .DATA_W (DATA_W), .NUM_SB (NUM_SB), .CORE_N (CORE_N), .NUM_PADS (NUM_PADS)
) u_chk (
  .clk (clk), .rst (rst), .wdt_ovf_i (wdt_ovf_i), .bus_rst_i (bus_rst_i),
  .sw_rst_bit_i (sw_rst_bit_i), .pd_i (pd_i), .sdn_en_bit_i (sdn_en_bit_i),
  .sw_sdn_bit_i (sw_sdn_bit_i), .sb_en_i (sb_en_i), .mode_o (mode_o),
  .clr_all_o (clr_all_o), .clr_swrst_o (clr_swrst_o), .clr_sden_o (clr_sden_o),
  .clr_swsdn_o (clr_swsdn_o), .pad_hiz_o (pad_hiz_o)
);

// File: tb/lpc_rsc_top_bench.sv
module lpc_rsc_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wdt = 1'b0, bus = 1'b0, swr = 1'b0, pd = 1'b0, sden = 1'b0, swsdn = 1'b0;
  logic [3:0]  sb = 4'h0;
  logic [2:0]  mode;
  logic        c_all, c_swrst, c_sden, c_swsdn;
  logic [13:0] hiz;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lpc_rsc_top u_lpc_rsc_top (
    .clk (clk), .rst (rst), .wdt_ovf_i (wdt), .bus_rst_i (bus),
    .sw_rst_bit_i (swr), .pd_i (pd), .sdn_en_bit_i (sden), .sw_sdn_bit_i (swsdn),
    .sb_en_i (sb), .mode_o (mode), .clr_all_o (c_all), .clr_swrst_o (c_swrst),
    .clr_sden_o (c_sden), .clr_swsdn_o (c_swsdn), .pad_hiz_o (hiz)
  );

  // Expected pad mask from R8 to R10: core 0..7, sideband 8..11 gated, 12..13 never.
  function automatic logic [13:0] exp_hiz(input logic active, input logic [3:0] en);
    return active ? {2'b00, en, 8'hFF} : 14'h0000;
  endfunction

  task automatic drive(input logic w, b, r, p, e, s, input logic [3:0] en);
    @(negedge clk);
    wdt = w; bus = b; swr = r; pd = p; sden = e; swsdn = s; sb = en;
  endtask

  // One edge after driving, then sample mid-cycle.
  task automatic expect_out(input string req, input logic [2:0] m,
                            input logic [3:0] clr, input logic [13:0] hz);
    @(posedge clk); #5;
    n_chk++;
    if (mode !== m || {c_all, c_swrst, c_sden, c_swsdn} !== clr || hiz !== hz) begin
      n_bad++;
      $display("FAIL %s: mode=%0d clr=%b hiz=%h expected mode=%0d clr=%b hiz=%h",
               req, mode, {c_all, c_swrst, c_sden, c_swsdn}, hiz, m, clr, hz);
    end
  endtask

  task automatic t_reset;    // R2 R8 R10
    expect_out("R2 reset", 3'd5, 4'b1111, exp_hiz(1'b1, 4'h0));
  endtask

  task automatic t_idle;     // R11 R1
    drive(0, 0, 0, 0, 0, 0, 4'h0);
    rst = 1'b0;
    expect_out("R11 idle after reset", 3'd0, 4'b0000, 14'h0000);
  endtask

  task automatic t_wdt;      // R2 R7 R9
    drive(1, 1, 1, 1, 1, 1, 4'hF);
    expect_out("R7 all sources, watchdog wins", 3'd5, 4'b1111, exp_hiz(1'b1, 4'hF));
  endtask

  task automatic t_bus;      // R3 R7
    drive(0, 1, 1, 1, 1, 1, 4'h3);
    expect_out("R3 bus reset over rest", 3'd4, 4'b0111, exp_hiz(1'b1, 4'h3));
  endtask

  task automatic t_swr;      // R4 R7
    drive(0, 0, 1, 1, 1, 1, 4'h0);
    expect_out("R4 software reset keeps own bit", 3'd3, 4'b0011, exp_hiz(1'b1, 4'h0));
  endtask

  task automatic t_hwsdn;    // R5 R7 R9
    drive(0, 0, 0, 1, 1, 1, 4'h5);
    expect_out("R5 hardware shutdown", 3'd2, 4'b0001, exp_hiz(1'b1, 4'h5));
  endtask

  task automatic t_swsdn;    // R6 R9
    drive(0, 0, 0, 0, 1, 1, 4'hA);
    expect_out("R6 software shutdown", 3'd1, 4'b0000, exp_hiz(1'b1, 4'hA));
  endtask

  task automatic t_gate;     // R6: shutdown inputs ignored without enable
    drive(0, 0, 0, 1, 0, 1, 4'hF);
    expect_out("R6 shutdown gated off", 3'd0, 4'b0000, 14'h0000);
  endtask

  task automatic t_release;  // R11 R8
    drive(0, 0, 0, 1, 1, 0, 4'h8);
    expect_out("R8 shutdown floats core", 3'd2, 4'b0001, exp_hiz(1'b1, 4'h8));
    drive(0, 0, 0, 0, 1, 0, 4'h8);
    expect_out("R11 first clock after release", 3'd0, 4'b0000, 14'h0000);
  endtask

  task automatic t_wdt_alone; // R2 R10
    drive(1, 0, 0, 0, 0, 0, 4'h6);
    expect_out("R2 watchdog alone", 3'd5, 4'b1111, exp_hiz(1'b1, 4'h6));
    drive(0, 0, 0, 0, 0, 0, 4'h6);
    expect_out("R11 after watchdog", 3'd0, 4'b0000, 14'h0000);
  endtask

  task automatic t_bus_alone; // R3 R1
    drive(0, 1, 0, 0, 0, 0, 4'h9);
    expect_out("R3 bus reset alone", 3'd4, 4'b0111, exp_hiz(1'b1, 4'h9));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_idle();
    t_wdt();
    t_bus();
    t_swr();
    t_hwsdn();
    t_swsdn();
    t_gate();
    t_release();
    t_wdt_alone();
    t_bus_alone();
    t_swsdn();
    t_gate();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule